// File: doc/BRIEF.md
# Paired-Counter PWM Generator

This block makes one pulse-width-modulated output from two down-counting channels. The leading channel runs as a free-running interval timer. Every time it expires, it reloads and produces a period event. The trailing channel is a one-shot timer. Each period event restarts it. While it counts, the output is held at its active level, so its load value sets the high time and the leading channel's load value sets the period.

Software programs a period value and a width value through a small write port. Those values sit in holding registers. They move into the counters only on a period event, so a new setting never truncates the cycle in progress.

A start strobe launches the leading channel at once and raises its event pulse. A stop strobe halts both channels and forces the output to its idle level. Counting advances only on clocks where the count enable is high. Each channel signals its own expiry with a one-clock pulse. A polarity input chooses whether the active level is high or low.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset, both interrupt pulses are low, the output is at its inactive level (pin equals `act_low`), and both holding registers read as zero.
- R2: A start strobe, when stop is not also high, makes `irq_period` pulse high in the very next cycle and loads the period value into the leading counter. When start and stop are high together, stop wins and no pulse appears.
- R3: While running, a period event recurs every P+1 enabled clocks, where P is the loaded period value. Each event is shown as a one-cycle pulse on `irq_period`.
- R4: On clocks where `cnt_en` is low, neither counter moves, so no new period or width expiry can occur.
- R5: With a width value W where 0 < W < P+1, the output is active for exactly W enabled clocks per period. It turns active in the cycle after the `irq_period` pulse.
- R6: A width value of 0 leaves the output inactive for the whole period, and `irq_width` does not pulse.
- R7: A width value W ≥ P+1 holds the output active continuously, because the next period event retriggers the width counter before it expires.
- R8: `irq_width` pulses for one cycle when the width countdown finishes. This is the cycle before the output returns to inactive. It also pulses when the countdown finishes on the same clock as a retrigger.
- R9: A write to the period value (`wr_sel`=0) or to the width value (`wr_sel`=1) is seen only at the next period event. A write on the same clock as an event is not used by that event.
- R10: A stop strobe halts both counters. From the next cycle until a later start, the output is inactive and neither interrupt pulses.
- R11: With `act_low`=0 the active level is high. With `act_low`=1 the output pin is inverted, so the active level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable; counters step only when high |
| start | input | 1 | Start strobe; begins a new period immediately |
| stop | input | 1 | Stop strobe; halts both channels, has priority over start |
| wr_en | input | 1 | Write strobe for the holding registers |
| wr_sel | input | 1 | 0 selects the period value, 1 selects the width value |
| wr_data | input | CNT_W | Value to write |
| act_low | input | 1 | Output polarity: 1 makes the active level low |
| irq_period | output | 1 | One-cycle pulse on each period event |
| irq_width | output | 1 | One-cycle pulse when the width countdown ends |
| pwm_pin | output | 1 | PWM output |

## Verification
The bench builds the block with an 8-bit counter width. At that width the saturation case, where the width value exceeds the period value, can be reached with a full period of a few hundred clocks. Periods short enough to step through many full cycles stay in range as well. With the small width, random period and width values land often on the edges that matter: zero width, width equal to period plus one, and period zero. Rewrites that straddle a reload event also occur often.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    // Selects which holding register a write reaches.
    typedef enum logic {
        SEL_PERIOD = 1'b0,
        SEL_WIDTH  = 1'b1
    } data_sel_e;

    // Chooses the electrical level that means "active" on the pin.
    typedef enum logic {
        LVL_HIGH = 1'b0,
        LVL_LOW  = 1'b1
    } act_lvl_e;

endpackage

// File: rtl/pwm_master_chan.sv
module pwm_master_chan
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] load_val,
    output logic             reload,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } mst_state_t;

    mst_state_t s_d, s_q;
    logic       expire_d;

    always_comb begin
        s_d      = s_q;
        expire_d = s_q.run && tick && (s_q.cnt == CNT_ZERO);
        reload   = !stop && (start || expire_d);
        s_d.irq  = reload;
        if (stop) begin
            s_d.run = 1'b0;
        end else if (reload) begin
            s_d.run = 1'b1;
            s_d.cnt = load_val;
        end else if (s_q.run && tick) begin
            s_d.cnt = s_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.irq;

    // R3: expiry reloads the counter from the holding value and pulses
    a_r3_reload_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && tick && s_q.cnt == CNT_ZERO && !stop)
        |=> (s_q.cnt == $past(load_val) && s_q.irq));

    // R4: no enable, no movement
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !tick && !start && !stop) |=> ($stable(s_q.cnt) && !s_q.irq));

    // R10: stop halts the channel
    a_r10_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!s_q.run && !s_q.irq));

    // R2: start without stop raises the event next cycle
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> (s_q.irq && s_q.run));

endmodule

// File: rtl/pwm_slave_chan.sv
module pwm_slave_chan
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig,
    input  logic             stop,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic             irq;
        logic [CNT_W-1:0] cnt;
    } slv_state_t;

    slv_state_t s_d, s_q;
    logic       last_d;

    always_comb begin
        s_d     = s_q;
        last_d  = s_q.busy && tick && (s_q.cnt == CNT_ONE);
        s_d.irq = !stop && last_d;
        if (stop) begin
            s_d.busy = 1'b0;
        end else if (trig) begin
            s_d.cnt  = load_val;
            s_d.busy = (load_val != CNT_ZERO);
        end else if (s_q.busy && tick) begin
            s_d.cnt = s_q.cnt - CNT_ONE;
            if (last_d) begin
                s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign irq  = s_q.irq;

    // R6: zero width never enters the busy state
    a_r6_zero_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && load_val == CNT_ZERO) |=> (!s_q.busy));

    // R5: a non-zero width starts a countdown from that value
    a_r5_width_load: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && load_val != CNT_ZERO) |=> (s_q.busy && s_q.cnt == $past(load_val)));

    // R8: the end of the countdown raises the width pulse
    a_r8_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && tick && s_q.cnt == CNT_ONE && !stop) |=> s_q.irq);

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_pair_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic stop,
    input  logic act_low,
    output logic pin
);
    logic     lvl_d, lvl_q;
    act_lvl_e pol;

    always_comb begin
        lvl_d = stop ? 1'b0 : busy;
        pol   = act_lvl_e'(act_low);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign pin = (pol == LVL_LOW) ? !lvl_q : lvl_q;

    // R10: stop forces the inactive level on the next cycle
    a_r10_forced_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (pin == act_low));

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             start,
    input  logic             stop,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             act_low,
    output logic             irq_period,
    output logic             irq_width,
    output logic             pwm_pin
);
    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
    } hold_regs_t;

    hold_regs_t r_d, r_q;
    data_sel_e  sel;
    logic       reload_w;
    logic       busy_w;

    always_comb begin
        r_d = r_q;
        sel = data_sel_e'(wr_sel);
        if (wr_en) begin
            if (sel == SEL_WIDTH) begin
                r_d.width = wr_data;
            end else begin
                r_d.period = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    pwm_master_chan #(.CNT_W(CNT_W)) i_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_en),
        .start    (start),
        .stop     (stop),
        .load_val (r_q.period),
        .reload   (reload_w),
        .irq      (irq_period)
    );

    pwm_slave_chan #(.CNT_W(CNT_W)) i_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_en),
        .trig     (reload_w),
        .stop     (stop),
        .load_val (r_q.width),
        .busy     (busy_w),
        .irq      (irq_width)
    );

    pwm_out_stage i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy_w),
        .stop    (stop),
        .act_low (act_low),
        .pin     (pwm_pin)
    );

    // R7: an active output stays active across a retrigger when width exceeds period
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && reload_w && r_q.width != '0) |=> busy_w);

endmodule

// File: tb/test_pwm_pair_timer.sv
`timescale 1ns/1ps
module test_pwm_pair_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0, start = 1'b0, stop = 1'b0;
    logic         wr_en = 1'b0, wr_sel = 1'b0, act_low = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         irq_period, irq_width, pwm_pin;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pwm_pair_timer #(.CNT_W(W)) i_pwm_pair_timer (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start), .stop(stop),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .act_low(act_low),
        .irq_period(irq_period), .irq_width(irq_width), .pwm_pin(pwm_pin)
    );

    // behavioural reference
    int m_left, s_left, reg_per, reg_wid;
    bit m_on, s_on, e_irqm, e_irqs, e_lvl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; s_left = 0; reg_per = 0; reg_wid = 0;
            m_on = 0; s_on = 0; e_irqm = 0; e_irqs = 0; e_lvl = 0;
        end else begin
            bit ev, nirqs, nlvl;
            ev    = !stop && (start || (m_on && cnt_en && m_left == 0));
            nirqs = !stop && s_on && cnt_en && s_left == 1;
            nlvl  = stop ? 1'b0 : s_on;
            if (stop) m_on = 0;
            else if (ev) begin m_on = 1; m_left = reg_per; end
            else if (m_on && cnt_en) m_left = m_left - 1;
            if (stop) s_on = 0;
            else if (ev) begin s_left = reg_wid; s_on = (reg_wid != 0); end
            else if (s_on && cnt_en) begin
                s_left = s_left - 1;
                if (s_left == 0) s_on = 0;
            end
            if (wr_en) begin
                if (wr_sel) reg_wid = int'(wr_data);
                else        reg_per = int'(wr_data);
            end
            e_irqm = ev; e_irqs = nirqs; e_lvl = nlvl;
        end
    end

    int act_cnt, hi_cnt, irqm_cnt, irqs_cnt;

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (irq_period !== e_irqm) begin
                errors++;
                $display("FAIL R3 irq_period got %0b exp %0b at %0t", irq_period, e_irqm, $time);
            end
            checks++;
            if (irq_width !== e_irqs) begin
                errors++;
                $display("FAIL R8 irq_width got %0b exp %0b at %0t", irq_width, e_irqs, $time);
            end
            checks++;
            if (pwm_pin !== (e_lvl ^ act_low)) begin
                errors++;
                $display("FAIL R5 pwm_pin got %0b exp %0b at %0t", pwm_pin, e_lvl ^ act_low, $time);
            end
            if (pwm_pin !== act_low) act_cnt++;
            if (pwm_pin) hi_cnt++;
            if (irq_period) irqm_cnt++;
            if (irq_width) irqs_cnt++;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic window(input int n);
        act_cnt = 0; hi_cnt = 0; irqm_cnt = 0; irqs_cnt = 0;
        cyc(n);
    endtask

    task automatic wr(input logic s, input int v);
        wr_en = 1'b1; wr_sel = s; wr_data = W'(v);
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; cyc(1); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; cyc(1); stop = 1'b0;
    endtask

    initial begin
        int n;
        #1;
        cyc(3);
        // R1: reset state
        check("R1 irq_period", int'(irq_period), 0);
        check("R1 irq_width", int'(irq_width), 0);
        check("R1 pwm_pin", int'(pwm_pin), 0);
        rst_n = 1'b1;
        cyc(2);
        check("R1 idle after reset", int'(pwm_pin), 0);

        // R5 / R3: period 5, width 2
        cnt_en = 1'b1;
        wr(1'b0, 4);
        wr(1'b1, 2);
        start = 1'b1; cyc(1); start = 1'b0;
        check("R2 start pulse", int'(irq_period), 1);
        cyc(12);
        window(20);
        check("R5 active count", act_cnt, 8);
        check("R3 period events", irqm_cnt, 4);
        check("R8 width pulses", irqs_cnt, 4);

        // R9: rewrite right after an event takes effect one period later
        while (!irq_period) cyc(1);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = W'(9);
        cyc(1);
        wr_en = 1'b0;
        n = 1;
        while (!irq_period && n < 1000) begin cyc(1); n++; end
        check("R9 old period kept", n, 5);
        n = 0;
        do begin cyc(1); n++; end while (!irq_period && n < 1000);
        check("R9 new period used", n, 10);

        // R6: zero width
        wr(1'b1, 0);
        cyc(25);
        window(30);
        check("R6 never active", act_cnt, 0);
        check("R6 no width pulse", irqs_cnt, 0);
        check("R6 periods still run", irqm_cnt, 3);

        // R7: width = period+1 and far above
        wr(1'b1, 10);
        cyc(25);
        window(30);
        check("R7 full duty at P+1", act_cnt, 30);
        check("R8 pulse at retrigger", irqs_cnt, 3);
        wr(1'b1, 255);
        cyc(25);
        window(30);
        check("R7 full duty saturated", act_cnt, 30);

        // R4: enable low freezes
        cnt_en = 1'b0;
        window(20);
        check("R4 no events", irqm_cnt, 0);
        check("R4 output held", act_cnt, 20);
        cnt_en = 1'b1;

        // R10: stop
        wr(1'b1, 3);
        cyc(25);
        pulse_stop();
        window(20);
        check("R10 inactive after stop", act_cnt, 0);
        check("R10 no period events", irqm_cnt, 0);
        check("R10 no width events", irqs_cnt, 0);

        // R2: stop beats start
        start = 1'b1; stop = 1'b1; cyc(1); start = 1'b0; stop = 1'b0;
        window(15);
        check("R2 stop wins", irqm_cnt, 0);

        // R11: active-low polarity
        act_low = 1'b1;
        cyc(1);
        check("R11 idle level high", int'(pwm_pin), 1);
        pulse_start();
        cyc(19);
        window(30);
        check("R11 high cycles", hi_cnt, 21);

        // mixed random traffic
        act_low = 1'b0;
        for (int i = 0; i < 2500; i++) begin
            cnt_en = ($urandom_range(0, 3) != 0);
            wr_en = ($urandom_range(0, 15) == 0);
            wr_sel = $urandom_range(0, 1);
            wr_data = W'($urandom_range(0, 14));
            start = ($urandom_range(0, 99) == 0);
            stop = ($urandom_range(0, 149) == 0);
            if ($urandom_range(0, 299) == 0) act_low = ~act_low;
            cyc(1);
        end
        wr_en = 1'b0; start = 1'b0; stop = 1'b0;
        cyc(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t;
        for (t = 0; t < 100000; t++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule